// File: doc/BRIEF.md
# Clock Bank Divider with Synchronous Stop

This block takes an undivided fast clock and a reference clock and drives four output banks of two clocks each. All logic runs on the fast clock. A shared counter sets the phase of every bank, and each bank turns that phase into its own waveform. Banks 1 and 2 give an undivided copy. Bank 3 can divide by 1, 2 or 4. Bank 4 can divide by 1 or 2, or give an inverted undivided copy. Bank 3 and bank 4 each choose their setting from a pair of three-level select pins. Every three-level pin arrives as a 2-bit code.

An active-low run input stops the outputs synchronously. When it is high, every bank except bank 2 goes to its stop level. Bank 2 keeps running so that it can still serve as loop feedback. A bank only enters or leaves its stopped state at a moment when its waveform already equals its stop level, so no short pulse can appear. A three-level test input can send the reference straight to all outputs. One of its settings instead keeps the internal path active and uses each bank's select pair as a per-bank disable.

"Undivided" means the waveform toggles on every fast-clock edge, so its period is two fast-clock cycles. Below, k is the number of rising fast-clock edges since reset was released, and c is k mod 8, which is the value of the shared counter.

Top module: `bank_clock_gen`

## Requirements
- R1: Each three-level pin is a 2-bit code: 2'b00 is LOW, 2'b01 is MID, 2'b10 is HIGH, and 2'b11 is also read as MID. A select pair is packed as {pin B in bits [3:2], pin A in bits [1:0]}. "LL" means both pins are LOW and "HH" means both pins are HIGH.
- R2: Banks 1 and 2 always run undivided. While a bank runs undivided, its output in cycle k is 1 when k is odd.
- R3: Bank 3 runs as follows. LL divides by 2, so the output is 1 when c mod 4 is 2 or more. HH divides by 4, so the output is 1 when c is 4 or more. Any other pair runs undivided.
- R4: Bank 4 runs as follows. LL divides by 2. HH gives the inverted undivided wave, so the output is 1 when k is even. Any other pair runs undivided.
- R5: Both outputs of a bank are always equal. All banks take their phase from the one shared counter, so they stay aligned to each other.
- R6: A new select value is first sampled on a fast-clock edge. It takes effect at the next edge on which c goes from 7 back to 0. Until that edge, the bank keeps its previous waveform.
- R7: While the test input is LOW and run_n is high, banks 1, 3 and 4 are held at their stop level. Bank 2 keeps toggling. While run_n is low, all banks run.
- R8: The stop level is LOW for every bank, except bank 4 in inverted mode. There it equals edge_rise: HIGH when edge_rise is 1 (rising-edge alignment) and LOW when edge_rise is 0.
- R9: A bank enters or leaves the stopped state only at an edge where its next waveform value equals its stop level. As a result, every high pulse of a divide-by-4 output lasts exactly 4 cycles, and every low pulse of an inverted output lasts exactly 1 cycle, even while run_n toggles.
- R10: When the test input is HIGH, or MID with run_n low, every output equals ref_clk without delay.
- R11: When the test input is MID and run_n is high, the internal path stays active. A bank whose select pair is LL is held at its stop level. Every other bank runs as selected and ignores the stop.
- R12: Reset is asynchronous and active low. During reset, and until the first stop-level boundary after it, all outputs are LOW and every bank's setting is undivided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Undivided fast clock that clocks all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock, routed to the outputs in bypass |
| test_lvl | input | 2 | Three-level test control code |
| run_n | input | 1 | Active-low run; high requests a stop |
| edge_rise | input | 1 | Edge alignment select; 1 = rising edge |
| sel1 | input | 4 | Bank 1 select pair (used only as a disable in the test sub-mode) |
| sel2 | input | 4 | Bank 2 select pair (used only as a disable in the test sub-mode) |
| sel3 | input | 4 | Bank 3 select pair |
| sel4 | input | 4 | Bank 4 select pair |
| q1 | output | OUTS_PER_BANK | Bank 1 outputs |
| q2 | output | OUTS_PER_BANK | Bank 2 (feedback) outputs |
| q3 | output | OUTS_PER_BANK | Bank 3 outputs |
| q4 | output | OUTS_PER_BANK | Bank 4 outputs |

## Verification
The bench builds the block with its default values: two outputs per bank and a largest divide of 4. With these values the shared counter wraps every 8 cycles. A 16-cycle window therefore covers every phase of every waveform, and a mode change, a stop or a restart settles within 24 cycles. Short random configurations can thus hit every select code, including the 2'b11 alias, and every stop level against a computed waveform. Directed cases pin down the exact wrap at which a new select value applies and the pulse widths while the stop input toggles.

// File: rtl/bank_clock_pkg.sv
`timescale 1ns/1ps
package bank_clock_pkg;
  localparam int DIV_LOG2_MAX  = 2;
  localparam int CNT_W         = DIV_LOG2_MAX + 1;
  localparam int NUM_BANKS     = 4;
  localparam int FEEDBACK_BANK = 1;
  localparam int SEL_W         = 4;

  typedef enum logic [1:0] {LVL_LOW, LVL_MID, LVL_HIGH} lvl_t;
  typedef enum logic [1:0] {MODE_DIV1, MODE_DIV2, MODE_DIVMAX, MODE_INV} mode_t;
  typedef enum logic [1:0] {KIND_PLAIN, KIND_DIVIDE, KIND_INVERT} kind_t;

  // 2'b11 is folded onto MID
  function automatic lvl_t decode_lvl(input logic [1:0] code);
    case (code)
      2'b00:   return LVL_LOW;
      2'b10:   return LVL_HIGH;
      default: return LVL_MID;
    endcase
  endfunction

  function automatic logic pair_both_low(input logic [SEL_W-1:0] sel);
    return (decode_lvl(sel[1:0]) == LVL_LOW) && (decode_lvl(sel[3:2]) == LVL_LOW);
  endfunction

  function automatic logic pair_both_high(input logic [SEL_W-1:0] sel);
    return (decode_lvl(sel[1:0]) == LVL_HIGH) && (decode_lvl(sel[3:2]) == LVL_HIGH);
  endfunction

  function automatic kind_t kind_of_bank(input int b);
    if (b == 2) return KIND_DIVIDE;
    if (b == 3) return KIND_INVERT;
    return KIND_PLAIN;
  endfunction

  function automatic mode_t select_mode(input kind_t kind, input logic [SEL_W-1:0] sel);
    mode_t m;
    m = MODE_DIV1;
    if (kind != KIND_PLAIN) begin
      if (pair_both_low(sel))
        m = MODE_DIV2;
      else if (pair_both_high(sel))
        m = (kind == KIND_DIVIDE) ? MODE_DIVMAX : MODE_INV;
    end
    return m;
  endfunction

  // waveform value for a given counter phase
  function automatic logic wave_bit(input mode_t m, input logic [CNT_W-1:0] c);
    case (m)
      MODE_DIV2:   return c[1];
      MODE_DIVMAX: return c[CNT_W-1];
      MODE_INV:    return ~c[0];
      default:     return c[0];
    endcase
  endfunction

  function automatic logic stop_level(input mode_t m, input logic edge_rise);
    return (m == MODE_INV) ? edge_rise : 1'b0;
  endfunction
endpackage

// File: rtl/bank_clock_counter.sv
`timescale 1ns/1ps
module bank_clock_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt_next,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign cnt_next = cnt_q + 1'b1;
  assign wrap     = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end
endmodule

// File: rtl/bank_clock_ctrl.sv
`timescale 1ns/1ps
module bank_clock_ctrl
  import bank_clock_pkg::*;
#(
  parameter int NB = 4,
  parameter int FB = 1
) (
  input  logic [1:0]          test_lvl,
  input  logic                run_n,
  input  logic [NB*SEL_W-1:0] sel_flat,
  output logic                bypass,
  output logic [NB-1:0]       want
);
  lvl_t tmode;
  logic sub_mode;

  assign tmode    = decode_lvl(test_lvl);
  assign bypass   = (tmode == LVL_HIGH) || ((tmode == LVL_MID) && !run_n);
  assign sub_mode = (tmode == LVL_MID) && run_n;

  for (genvar b = 0; b < NB; b++) begin : g_want
    assign want[b] = sub_mode ? !pair_both_low(sel_flat[b*SEL_W +: SEL_W])
                              : (!run_n || (b == FB));
  end
endmodule

// File: rtl/bank_clock_lane.sv
`timescale 1ns/1ps
module bank_clock_lane
  import bank_clock_pkg::*;
#(
  parameter kind_t KIND = KIND_PLAIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic             wrap,
  input  logic [SEL_W-1:0] sel,
  input  logic             want,
  input  logic             edge_rise,
  output logic [1:0]       mode_o,
  output logic             gate_o,
  output logic             level_o,
  output logic             q_o
);
  mode_t pend_q, mode_q, mode_new;
  logic  lvl_new, w_new, gate_new;

  always_comb begin
    mode_new = wrap ? pend_q : mode_q;
    lvl_new  = stop_level(mode_new, edge_rise);
    w_new    = wave_bit(mode_new, cnt_next);
    // gate moves only when the wave sits at the stop level
    gate_new = (w_new == lvl_new) ? want : gate_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= MODE_DIV1;
      mode_q <= MODE_DIV1;
      gate_o <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      pend_q <= select_mode(KIND, sel);
      if (wrap) mode_q <= pend_q;
      gate_o <= gate_new;
      q_o    <= gate_new ? w_new : lvl_new;
    end
  end

  assign mode_o  = mode_q;
  assign level_o = stop_level(mode_q, edge_rise);
endmodule

// File: rtl/bank_clock_gen.sv
`timescale 1ns/1ps
module bank_clock_gen
  import bank_clock_pkg::*;
#(
  parameter int OUTS_PER_BANK = 2
) (
  input  logic                     fast_clk,
  input  logic                     rst_n,
  input  logic                     ref_clk,
  input  logic [1:0]               test_lvl,
  input  logic                     run_n,
  input  logic                     edge_rise,
  input  logic [SEL_W-1:0]         sel1,
  input  logic [SEL_W-1:0]         sel2,
  input  logic [SEL_W-1:0]         sel3,
  input  logic [SEL_W-1:0]         sel4,
  output logic [OUTS_PER_BANK-1:0] q1,
  output logic [OUTS_PER_BANK-1:0] q2,
  output logic [OUTS_PER_BANK-1:0] q3,
  output logic [OUTS_PER_BANK-1:0] q4
);
  logic [NUM_BANKS*SEL_W-1:0] sel_flat;
  logic [CNT_W-1:0]           cnt_next;
  logic                       wrap;
  logic                       bypass;
  logic [NUM_BANKS-1:0]       want;
  logic [NUM_BANKS-1:0]       gate_vec;
  logic [NUM_BANKS-1:0]       level_vec;
  logic [NUM_BANKS-1:0]       qreg_vec;
  logic [2*NUM_BANKS-1:0]     mode_vec;

  assign sel_flat = {sel4, sel3, sel2, sel1};

  bank_clock_counter #(.W(CNT_W)) u_cnt (
    .clk      (fast_clk),
    .rst_n    (rst_n),
    .cnt_next (cnt_next),
    .wrap     (wrap)
  );

  bank_clock_ctrl #(.NB(NUM_BANKS), .FB(FEEDBACK_BANK)) u_ctrl (
    .test_lvl (test_lvl),
    .run_n    (run_n),
    .sel_flat (sel_flat),
    .bypass   (bypass),
    .want     (want)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
    bank_clock_lane #(.KIND(kind_of_bank(b))) u_lane (
      .clk       (fast_clk),
      .rst_n     (rst_n),
      .cnt_next  (cnt_next),
      .wrap      (wrap),
      .sel       (sel_flat[b*SEL_W +: SEL_W]),
      .want      (want[b]),
      .edge_rise (edge_rise),
      .mode_o    (mode_vec[2*b +: 2]),
      .gate_o    (gate_vec[b]),
      .level_o   (level_vec[b]),
      .q_o       (qreg_vec[b])
    );
  end

  assign q1 = bypass ? {OUTS_PER_BANK{ref_clk}} : {OUTS_PER_BANK{qreg_vec[0]}};
  assign q2 = bypass ? {OUTS_PER_BANK{ref_clk}} : {OUTS_PER_BANK{qreg_vec[1]}};
  assign q3 = bypass ? {OUTS_PER_BANK{ref_clk}} : {OUTS_PER_BANK{qreg_vec[2]}};
  assign q4 = bypass ? {OUTS_PER_BANK{ref_clk}} : {OUTS_PER_BANK{qreg_vec[3]}};
endmodule

// File: rtl/bank_clock_gen_chk.sv
`timescale 1ns/1ps
module bank_clock_gen_chk
  import bank_clock_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   edge_rise,
  input logic [1:0]             test_lvl,
  input logic                   bypass,
  input logic                   wrap,
  input logic [NUM_BANKS-1:0]   gate_vec,
  input logic [NUM_BANKS-1:0]   level_vec,
  input logic [NUM_BANKS-1:0]   qreg_vec,
  input logic [2*NUM_BANKS-1:0] mode_vec
);
  always @(negedge clk) begin
    if (!rst_n && !bypass)
      assert_reset_low_R12: assert (qreg_vec == '0)
        else $error("outputs not low during reset");
  end

  // feedback bank never closes while test stays LOW
  assert_feedback_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_lvl == 2'b00 && $past(test_lvl) == 2'b00) |-> !$fell(gate_vec[FEEDBACK_BANK]));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    assert_mode_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(mode_vec[2*b +: 2]));

    assert_gate_at_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gate_vec[b]) |-> (qreg_vec[b] == level_vec[b]));

    assert_stopped_flat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_vec[b] && !$past(gate_vec[b]) && $stable(mode_vec[2*b +: 2]) &&
       ($past(edge_rise) == $past(edge_rise, 2))) |-> $stable(qreg_vec[b]));
  end
endmodule

bind bank_clock_gen bank_clock_gen_chk u_chk (
  .clk       (fast_clk),
  .rst_n     (rst_n),
  .edge_rise (edge_rise),
  .test_lvl  (test_lvl),
  .bypass    (bypass),
  .wrap      (wrap),
  .gate_vec  (gate_vec),
  .level_vec (level_vec),
  .qreg_vec  (qreg_vec),
  .mode_vec  (mode_vec)
);

// File: tb/sim_bank_clock_gen.sv
`timescale 1ns/1ps
module sim_bank_clock_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic [1:0] test_lvl = 2'b00;
  logic       run_n = 1'b0;
  logic       edge_rise = 1'b0;
  logic [3:0] bsel [4];
  logic [1:0] q1, q2, q3, q4;
  int         k = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  bank_clock_gen u0 (
    .fast_clk (clk), .rst_n (rst_n), .ref_clk (ref_clk),
    .test_lvl (test_lvl), .run_n (run_n), .edge_rise (edge_rise),
    .sel1 (bsel[0]), .sel2 (bsel[1]), .sel3 (bsel[2]), .sel4 (bsel[3]),
    .q1 (q1), .q2 (q2), .q3 (q3), .q4 (q4)
  );

  function automatic logic [1:0] get_q(input int b);
    case (b)
      0: return q1;
      1: return q2;
      2: return q3;
      default: return q4;
    endcase
  endfunction

  function automatic bit is_ll(input logic [3:0] s);
    return s[1:0] == 2'b00 && s[3:2] == 2'b00;
  endfunction

  // half period in cycles; 0 means inverted undivided
  function automatic int half_of(input int b, input logic [3:0] s);
    if (b < 2) return 1;
    if (is_ll(s)) return 2;
    if (s[1:0] == 2'b10 && s[3:2] == 2'b10) return (b == 2) ? 4 : 0;
    return 1;
  endfunction

  function automatic bit exp_bit(input int b, input int kk);
    int  h;
    bit  mid, run, lvl, wave;
    h    = half_of(b, bsel[b]);
    lvl  = (h == 0) ? edge_rise : 1'b0;
    wave = (h == 0) ? (kk % 2 == 0) : ((kk % (2 * h)) >= h);
    mid  = (test_lvl == 2'b01) || (test_lvl == 2'b11);
    if (test_lvl == 2'b10 || (mid && !run_n)) return ref_clk;
    if (mid) run = !is_ll(bsel[b]);
    else     run = !run_n || (b == 1);
    return run ? wave : lvl;
  endfunction

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s k=%0d got %0d expected %0d", tag, k, got, exp);
    end
  endtask

  task automatic check_window(input int n, input string tag);
    repeat (n) begin
      @(negedge clk);
      for (int b = 0; b < 4; b++) begin
        for (int j = 0; j < 2; j++) begin
          bit g, e;
          g = get_q(b)[j];
          e = exp_bit(b, k);
          check(g == e, $sformatf("%s bank%0d out%0d", tag, b + 1, j), g, e);
        end
      end
    end
  endtask

  task automatic settle_and_check(input string tag);
    repeat (24) @(negedge clk);
    check_window(16, tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < 4; b++) bsel[b] = 4'b0000;

    // R12: reset state
    repeat (3) @(negedge clk);
    check({q1, q2, q3, q4} == 8'h00, "R12 in reset", {q1, q2, q3, q4}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({q1, q2, q3, q4} == 8'h00, "R12 first cycle", {q1, q2, q3, q4}, 0);

    // R2 R3 R4: base modes
    bsel[2] = 4'b0101; bsel[3] = 4'b0000;
    settle_and_check("R2 R3 R4 div1/div2");
    bsel[2] = 4'b0000; bsel[3] = 4'b0111;
    settle_and_check("R3 div2, R1 mixed pair");
    bsel[2] = 4'b1010; bsel[3] = 4'b1010; edge_rise = 1'b1;
    settle_and_check("R3 R4 R5 div4/inverted");

    // R7 R8: stop
    run_n = 1'b1;
    settle_and_check("R7 R8 stop level high");
    edge_rise = 1'b0;
    settle_and_check("R8 stop level low");
    run_n = 1'b0;
    settle_and_check("R7 restart");

    // R6: select applies at counter wrap
    bsel[2] = 4'b0101;
    repeat (24) @(negedge clk);
    while (k % 8 != 2) @(negedge clk);
    bsel[2] = 4'b1010;
    for (int i = 0; i < 13; i++) begin
      bit e;
      @(negedge clk);
      e = (i < 5) ? (k % 2 == 1) : (k % 8 >= 4);
      check(q3[0] == e, "R6 select at wrap", q3[0], e);
    end

    // R9: no runt pulses while the stop toggles
    bsel[2] = 4'b1010; bsel[3] = 4'b1010; edge_rise = 1'b1; run_n = 1'b0;
    repeat (24) @(negedge clk);
    while (k % 8 != 0) @(negedge clk);
    begin
      int h3 = 0, l4 = 0, p3 = 0, p4 = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (q3[0]) h3++;
        else if (h3 > 0) begin
          check(h3 == 4, "R9 div4 high width", h3, 4); h3 = 0; p3++;
        end
        if (!q4[0]) l4++;
        else if (l4 > 0) begin
          check(l4 == 1, "R9 inverted low width", l4, 1); l4 = 0; p4++;
        end
        if ($urandom_range(0, 4) == 0) run_n = ~run_n;
      end
      check(p3 > 0 && p4 > 0, "R9 pulses seen", p3, 1);
    end
    run_n = 1'b0;

    // R11 and R1: test MID sub-mode, code 11 read as MID
    bsel[0] = 4'b0000; bsel[1] = 4'b0001; bsel[2] = 4'b1010; bsel[3] = 4'b0000;
    test_lvl = 2'b01; run_n = 1'b1;
    settle_and_check("R11 per-bank disable");
    bsel[0] = 4'b0100; bsel[1] = 4'b0000; bsel[3] = 4'b1010;
    test_lvl = 2'b11;
    settle_and_check("R1 R11 code 11 as MID");

    // R10: bypass
    for (int pass = 0; pass < 2; pass++) begin
      test_lvl = (pass == 0) ? 2'b10 : 2'b01;
      run_n = (pass == 0) ? 1'b1 : 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        ref_clk = $urandom_range(0, 1);
        #1;
        check({q1, q2, q3, q4} == {8{ref_clk}}, "R10 bypass", {q1, q2, q3, q4}, {8{ref_clk}});
      end
    end
    ref_clk = 1'b0;

    // random configurations
    for (int it = 0; it < 24; it++) begin
      for (int b = 0; b < 4; b++) bsel[b] = 4'($urandom_range(0, 15));
      test_lvl  = ($urandom_range(0, 3) == 0) ? 2'b01 : 2'b00;
      run_n     = $urandom_range(0, 1);
      edge_rise = $urandom_range(0, 1);
      settle_and_check("R3 R4 R7 R8 R11 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at k=%0d", k);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule